// File: doc/BRIEF.md
# Bidirectional Switch Commutation Sequencer

This block drives the gates of one output phase of a direct three-input, three-output AC converter. That output can be tied to any of three input phases, and each tie is a bidirectional switch built from two unidirectional halves. Each half has its own gate. The forward half carries current from the input toward the output. The reverse half carries current from the output back to the input. The block therefore has six gate outputs. A modulator supplies a 2-bit code that names the input phase to connect. The sequencer runs on a fast step clock.

When the requested input changes, the output cannot be switched in a single step. Doing so would either short two input phases or open the inductive load path. The sequencer instead moves the connection over four clock steps. The order of the steps depends on the sign of the load current, which is sampled when the move begins. Outside a move, both halves of the selected switch stay on, so current can flow in either direction. A converter instantiates one sequencer for each output phase.

Top module: `phase_commutator`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) selects input a. After that edge, `fwd_gate` = 3'b001 and `rev_gate` = 3'b001. Bit i of each gate vector belongs to input code i: code 0 is a, 1 is b, 2 is c.
- R2: While no move is in progress, both halves of the selected switch are on and every other gate is off.
- R3: A legal code that differs from the selected input starts a move at the next edge. If `cur_pos` = 1 (current flowing toward the output, carried by the forward half), the gates follow four edges in turn. Edge 1: only the old forward half is on. Edge 2: the old and new forward halves are on. Edge 3: only the new forward half is on. Edge 4: both halves of the new switch are on.
- R4: With `cur_pos` = 0, a move follows the same four edges as R3 with the roles of forward and reverse halves swapped.
- R5: A move lasts exactly four edges. A new request present at the fourth edge's following edge starts the next move at once.
- R6: A code change that arrives during a move has no effect until the move completes. The code present after completion is then applied.
- R7: Code 2'b11 is ignored, and the present switch stays fully on.
- R8: A code equal to the selected input causes no change in any gate.
- R9: A forward half and a reverse half on two different inputs are never on together, so no path exists between two input phases.
- R10: At least one gate is always on. During a move, a half that conducts in the sampled current direction is always on.
- R11: The current sign is sampled when a move starts. A sign change during the move does not alter its steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_code | input | 2 | Requested input phase (0=a, 1=b, 2=c, 3 illegal) |
| cur_pos | input | 1 | Load current sign, 1 = toward the output |
| fwd_gate | output | 3 | Forward-half gate per input |
| rev_gate | output | 3 | Reverse-half gate per input |

## Verification
The no-open property during a move (R10) assumes that the real load current does not reverse while a move is in progress. That property is checked against the sign sampled inside the block, not against the live `cur_pos` pin. The short-circuit and step-order properties hold for any input sequence.

The stimulus covers scripted cases and a long pseudo-random run. Both flip `cur_pos` freely, including in the middle of a move. The bench model, like the assertions, judges the outputs only against the sign sampled when the move began.

// File: rtl/commut_pkg.sv
package commut_pkg;

  // Move progress, one state per commutation step.
  typedef enum logic [1:0] {
    ST_HOLD      = 2'd0,  // selected switch fully on
    ST_DROP_IDLE = 2'd1,  // old non-carrying half released
    ST_OVERLAP   = 2'd2,  // carrying halves of old and new both on
    ST_HANDOVER  = 2'd3   // old carrying half released
  } step_e;

  // Returns {carrying_half_on, other_half_on} for one input.
  function automatic logic [1:0] half_pattern(step_e st, logic is_cur, logic is_nxt);
    logic carry_on;
    logic other_on;
    carry_on = 1'b0;
    other_on = 1'b0;
    unique case (st)
      ST_HOLD: begin
        carry_on = is_cur;
        other_on = is_cur;
      end
      ST_DROP_IDLE: carry_on = is_cur;
      ST_OVERLAP:   carry_on = is_cur | is_nxt;
      ST_HANDOVER:  carry_on = is_nxt;
      default: ;
    endcase
    return {carry_on, other_on};
  endfunction

endpackage

// File: rtl/commut_req_filter.sv
module commut_req_filter #(
  parameter int NUM_IN = 3,
  parameter int CODE_W = $clog2(NUM_IN)
) (
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] cur_sel,
  input  logic              busy,
  output logic              start
);
  localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_IN);

  logic legal;

  always_comb begin
    legal = ({1'b0, code} < LIMIT);
    start = legal && (code != cur_sel) && !busy;
  end
endmodule

// File: rtl/commut_step_ctrl.sv
module commut_step_ctrl
  import commut_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int CODE_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CODE_W-1:0] target,
  input  logic              dir_in,
  output step_e             step,
  output logic [CODE_W-1:0] cur_sel,
  output logic [CODE_W-1:0] nxt_sel,
  output logic              dir_q,
  output logic              busy
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step    <= ST_HOLD;
      cur_sel <= '0;
      nxt_sel <= '0;
      dir_q   <= 1'b1;
    end else begin
      unique case (step)
        ST_HOLD: begin
          if (start) begin
            nxt_sel <= target;
            dir_q   <= dir_in;
            step    <= ST_DROP_IDLE;
          end
        end
        ST_DROP_IDLE: step <= ST_OVERLAP;
        ST_OVERLAP:   step <= ST_HANDOVER;
        ST_HANDOVER: begin
          cur_sel <= nxt_sel;
          step    <= ST_HOLD;
        end
        default: step <= ST_HOLD;
      endcase
    end
  end

  assign busy = (step != ST_HOLD);
endmodule

// File: rtl/commut_gate_map.sv
module commut_gate_map
  import commut_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int CODE_W = $clog2(NUM_IN)
) (
  input  step_e             step,
  input  logic [CODE_W-1:0] cur_sel,
  input  logic [CODE_W-1:0] nxt_sel,
  input  logic              dir_q,
  output logic [NUM_IN-1:0] fwd,
  output logic [NUM_IN-1:0] rev
);
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    logic [1:0] pat;
    always_comb begin
      pat    = half_pattern(step, cur_sel == CODE_W'(i), nxt_sel == CODE_W'(i));
      fwd[i] = dir_q ? pat[1] : pat[0];
      rev[i] = dir_q ? pat[0] : pat[1];
    end
  end
endmodule

// File: rtl/phase_commutator.sv
module phase_commutator
  import commut_pkg::*;
#(
  parameter int NUM_IN = 3,
  parameter int CODE_W = $clog2(NUM_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] sel_code,
  input  logic              cur_pos,
  output logic [NUM_IN-1:0] fwd_gate,
  output logic [NUM_IN-1:0] rev_gate
);
  step_e             seq_step;
  logic [CODE_W-1:0] seq_cur;
  logic [CODE_W-1:0] seq_nxt;
  logic              seq_dir;
  logic              seq_busy;
  logic              seq_start;

  commut_req_filter #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_filt (
    .code    (sel_code),
    .cur_sel (seq_cur),
    .busy    (seq_busy),
    .start   (seq_start)
  );

  commut_step_ctrl #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (seq_start),
    .target  (sel_code),
    .dir_in  (cur_pos),
    .step    (seq_step),
    .cur_sel (seq_cur),
    .nxt_sel (seq_nxt),
    .dir_q   (seq_dir),
    .busy    (seq_busy)
  );

  commut_gate_map #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_map (
    .step    (seq_step),
    .cur_sel (seq_cur),
    .nxt_sel (seq_nxt),
    .dir_q   (seq_dir),
    .fwd     (fwd_gate),
    .rev     (rev_gate)
  );
endmodule

// File: rtl/commut_chk.sv
module commut_chk #(
  parameter int NUM_IN = 3,
  parameter int CODE_W = $clog2(NUM_IN)
) (
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] sel_code,
  input logic [NUM_IN-1:0] fwd_gate,
  input logic [NUM_IN-1:0] rev_gate,
  input logic              busy,
  input logic              dir
);
  localparam logic [CODE_W:0] LIMIT = (CODE_W+1)'(NUM_IN);

  // 1 when a forward half and a reverse half on different inputs are both on.
  function automatic logic cross_path(logic [NUM_IN-1:0] f, logic [NUM_IN-1:0] r);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_IN; i++)
      for (int j = 0; j < NUM_IN; j++)
        if (i != j && f[i] && r[j]) hit = 1'b1;
    return hit;
  endfunction

  logic sel_legal;
  logic sel_is_held;
  always_comb begin
    sel_legal   = ({1'b0, sel_code} < LIMIT);
    sel_is_held = sel_legal && fwd_gate[sel_code] && rev_gate[sel_code];
  end

  assert_no_short_R9: assert property (@(posedge clk) disable iff (rst)
    !cross_path(fwd_gate, rev_gate));

  assert_never_open_R10: assert property (@(posedge clk) disable iff (rst)
    (|(fwd_gate | rev_gate)));

  assert_carry_kept_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> (dir ? (|fwd_gate) : (|rev_gate)));

  assert_steady_full_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (fwd_gate == rev_gate) && ($countones(fwd_gate) == 1));

  assert_move_len_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> busy ##1 busy ##1 busy ##1 !busy);

  assert_illegal_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (!busy && !sel_legal) |=> !busy);

  assert_same_code_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && sel_is_held) |=> ($stable(fwd_gate) && $stable(rev_gate)));

  assert_dir_latched_R11: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dir));
endmodule

bind phase_commutator commut_chk #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sel_code (sel_code),
  .fwd_gate (fwd_gate),
  .rev_gate (rev_gate),
  .busy     (seq_busy),
  .dir      (seq_dir)
);

// File: tb/sim_phase_commutator.sv
module sim_phase_commutator;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] code = 2'd0;
  logic       sign = 1'b1;
  logic [2:0] fwd;
  logic [2:0] rev;

  always #4 clk = ~clk;

  phase_commutator u0 (
    .clk      (clk),
    .rst      (rst),
    .sel_code (code),
    .cur_pos  (sign),
    .fwd_gate (fwd),
    .rev_gate (rev)
  );

  typedef struct {
    logic [2:0] f;
    logic [2:0] r;
    string      tag;
  } exp_t;

  exp_t q[$];
  exp_t got;
  int   n_cmp = 0;
  int   n_bad = 0;

  // Bench model: a step counter, 0 = holding, 1..3 = move steps.
  int   m_cur = 0;
  int   m_old = 0;
  int   m_new = 0;
  int   m_cnt = 0;
  logic m_dir = 1'b1;

  task automatic drive(input logic r_i, input logic [1:0] c, input logic s, input string tag);
    exp_t e;
    logic [2:0] on_c;
    logic [2:0] on_n;
    @(negedge clk);
    rst  = r_i;
    code = c;
    sign = s;
    if (r_i) begin
      m_cur = 0;
      m_cnt = 0;
    end else if (m_cnt == 0) begin
      if (c != 2'd3 && int'(c) != m_cur) begin
        m_old = m_cur;
        m_new = int'(c);
        m_dir = s;
        m_cnt = 1;
      end
    end else if (m_cnt == 3) begin
      m_cur = m_new;
      m_cnt = 0;
    end else begin
      m_cnt++;
    end
    on_c = '0;
    on_n = '0;
    case (m_cnt)
      0: begin on_c[m_cur] = 1'b1; on_n[m_cur] = 1'b1; end
      1: on_c[m_old] = 1'b1;
      2: begin on_c[m_old] = 1'b1; on_c[m_new] = 1'b1; end
      default: on_c[m_new] = 1'b1;
    endcase
    e.f   = m_dir ? on_c : on_n;
    e.r   = m_dir ? on_n : on_c;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: sample 2 ns after each rising edge.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      got = q.pop_front();
      n_cmp++;
      if (fwd !== got.f || rev !== got.r) begin
        n_bad++;
        $display("FAIL %s: fwd=%b rev=%b expected fwd=%b rev=%b", got.tag, fwd, rev, got.f, got.r);
      end
      n_cmp++;
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          if (i != j && fwd[i] && rev[j]) begin
            n_bad++;
            $display("FAIL R9 short: fwd=%b rev=%b expected no cross pair", fwd, rev);
          end
      n_cmp++;
      if ((fwd | rev) == 3'b000) begin
        n_bad++;
        $display("FAIL R10 open: fwd=%b rev=%b expected some gate on", fwd, rev);
      end
    end
  end

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R5 watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lf;
    lf = 16'hACE1;
    repeat (2) drive(1'b1, 2'd0, 1'b1, "R1 reset state");
    repeat (3) drive(1'b0, 2'd0, 1'b1, "R2 R8 hold input a");
    repeat (5) drive(1'b0, 2'd1, 1'b1, "R3 positive move a to b");
    repeat (5) drive(1'b0, 2'd2, 1'b0, "R4 negative move b to c");
    repeat (4) drive(1'b0, 2'd3, 1'b1, "R7 illegal code ignored");
    drive(1'b0, 2'd0, 1'b1, "R6 move c to a starts");
    repeat (8) drive(1'b0, 2'd1, 1'b1, "R6 held request to b");
    drive(1'b0, 2'd2, 1'b1, "R11 move starts positive");
    repeat (5) drive(1'b0, 2'd2, 1'b0, "R11 sign flipped mid move");
    for (int k = 0; k < 12; k++)
      drive(1'b0, 2'(k % 3), 1'(k % 2), "R5 back-to-back requests");
    for (int k = 0; k < 1500; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[15:10] == 6'd0, lf[1:0], lf[5], "R9 R10 random run");
    end
    drive(1'b0, 2'd3, 1'b1, "R7 final idle");
    @(posedge clk);
    #3;
    summary();
    $finish;
  end
endmodule